// File: doc/BRIEF.md
# Word Stack Push/Pop Engine

This block moves 16-bit words between a caller and a stack held in byte-wide memory. It keeps its own 16-bit stack pointer. Each command carries a stack segment value, and the segment and pointer together form 20-bit physical addresses. A push splits the data word into two byte writes and then lowers the pointer by two. A pop issues two byte reads, joins the bytes into a word, returns the word with a one-cycle strobe and raises the pointer by two.

A processor front end drives the block for push and pop, and for call and return. A call saves the return offset with a push, and a return restores it with a pop. Stack transfers are always whole words. Every byte access is one request/acknowledge handshake on the memory port, and the memory may add any number of wait states.

Top module: `stack_word_engine`

## Requirements
- R1: After reset the pointer `sp` is SP_INIT (default 0), `cmd_ready` is 1, and `mem_req` and `pop_valid` are 0.
- R2: A push (`cmd_pop`=0) makes its first memory access a write (`mem_we`=1) of data bits [15:8] at offset sp-1.
- R3: The second access of a push writes data bits [7:0] at offset sp-2. The high byte always goes first.
- R4: The pointer drops by 2 when the second push byte completes. At all other times it holds its value.
- R5: A pop (`cmd_pop`=1) reads (`mem_we`=0) the byte at offset sp first, then the byte at offset sp+1.
- R6: When a pop ends, `pop_valid` is high for one cycle and `pop_data` = {byte at sp+1, byte at sp}. In the same cycle the pointer rises by 2.
- R7: Each physical address is (`cmd_seg` × 16 + offset) mod 2^20. The segment is captured when the command is accepted.
- R8: Offset arithmetic (sp-1, sp-2, sp+1, sp±2) wraps modulo 2^16 before the segment is added.
- R9: Each byte access is one handshake: `mem_req` stays high, and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged, until a cycle in which `mem_ack` is high.
- R10: From acceptance until the second handshake, `cmd_ready` is 0 and `mem_req` is never high while `cmd_ready` is 1. Commands offered while busy are ignored: they cause no memory access, no pointer change and no `pop_valid`.
- R11: A word pushed and then popped with the same segment comes back unchanged (return offset save and restore).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_data | input | 16 | Word to push |
| cmd_seg | input | 16 | Stack segment value for this command |
| cmd_ready | output | 1 | Idle; a command is accepted when cmd_valid is also high |
| sp | output | 16 | Current stack pointer |
| pop_valid | output | 1 | One-cycle strobe with popped word |
| pop_data | output | 16 | Popped word |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |

## Verification
A directed push from the reset pointer of zero, with a nonzero segment, shows whether offsets wrap within 16 bits rather than carrying into the segment. A push with segment FFFFh shows the 20-bit wrap of the physical address. Push/pop pairs with different data values separate correct byte placement from swapped bytes. Commands offered during a slow, wait-stated transfer, with the opposite direction and inverted data, show whether busy commands leak in. After these, random sequences of pushes and pops over several segments, with 0 to 3 wait states per byte, test ordering, handshake stability and pointer tracking together.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND
  } stk_state_e;
endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFF_W + SEG_SHIFT
) (
  input  logic [OFF_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys
);
  // segment scaled by 2^SEG_SHIFT plus offset, truncated to PA_W bits
  always_comb begin
    phys = (PA_W'(seg) << SEG_SHIFT) + PA_W'(off);
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int OFF_W = 16,
  parameter logic [OFF_W-1:0] SP_INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             step_up,
  output logic [OFF_W-1:0] sp_q
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_INIT;
    end else if (step_en) begin
      sp_q <= step_up ? sp_q + STEP : sp_q - STEP;
    end
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int DW        = 16,
  parameter int SEG_SHIFT = 4,
  localparam int BW       = DW / 2,
  localparam int PA_W     = OFF_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_pop,
  input  logic [DW-1:0]    cmd_data,
  input  logic [OFF_W-1:0] cmd_seg,
  output logic             cmd_ready,
  input  logic [OFF_W-1:0] sp,
  output logic             sp_step,
  output logic             sp_up,
  output logic [OFF_W-1:0] sel_seg,
  output logic [OFF_W-1:0] sel_off,
  input  logic [PA_W-1:0]  phys,
  output logic             pop_valid,
  output logic [DW-1:0]    pop_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [BW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [BW-1:0]    mem_rdata
);
  localparam logic [OFF_W-1:0] ONE = OFF_W'(1);
  localparam logic [OFF_W-1:0] TWO = OFF_W'(2);

  stk_state_e       state;
  logic             pop_q;
  logic [OFF_W-1:0] seg_q;
  logic [DW-1:0]    hold_q;
  logic [BW-1:0]    low_q;

  // next address source: offset for the access about to be issued
  always_comb begin
    sel_seg = seg_q;
    sel_off = sp;
    case (state)
      ST_IDLE: begin
        sel_seg = cmd_seg;
        sel_off = cmd_pop ? sp : sp - ONE;
      end
      ST_FIRST:  sel_off = pop_q ? sp + ONE : sp - TWO;
      default:   sel_off = sp;
    endcase
  end

  always_comb begin
    sp_step = (state == ST_SECOND) && mem_ack;
    sp_up   = pop_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_ready <= 1'b1;
      pop_q     <= 1'b0;
      seg_q     <= '0;
      hold_q    <= '0;
      low_q     <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      pop_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            seg_q     <= cmd_seg;
            pop_q     <= cmd_pop;
            hold_q    <= cmd_data;
            cmd_ready <= 1'b0;
            mem_req   <= 1'b1;
            mem_we    <= ~cmd_pop;
            mem_addr  <= phys;
            mem_wdata <= cmd_data[DW-1:BW];
            state     <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (mem_ack) begin
            low_q     <= mem_rdata;
            mem_addr  <= phys;
            mem_wdata <= hold_q[BW-1:0];
            state     <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cmd_ready <= 1'b1;
            state     <= ST_IDLE;
            if (pop_q) begin
              pop_valid <= 1'b1;
              pop_data  <= {mem_rdata, low_q};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_word_engine.sv
module stack_word_engine #(
  parameter int OFF_W     = 16,
  parameter int DW        = 16,
  parameter int SEG_SHIFT = 4,
  parameter logic [OFF_W-1:0] SP_INIT = '0,
  localparam int BW       = DW / 2,
  localparam int PA_W     = OFF_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_pop,
  input  logic [DW-1:0]    cmd_data,
  input  logic [OFF_W-1:0] cmd_seg,
  output logic             cmd_ready,
  output logic [OFF_W-1:0] sp,
  output logic             pop_valid,
  output logic [DW-1:0]    pop_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [BW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [BW-1:0]    mem_rdata
);
  logic             sp_step, sp_up;
  logic [OFF_W-1:0] sel_seg, sel_off;
  logic [PA_W-1:0]  phys;

  stk_ptr #(.OFF_W(OFF_W), .SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst(rst), .step_en(sp_step), .step_up(sp_up), .sp_q(sp)
  );

  stk_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_agen (
    .seg(sel_seg), .off(sel_off), .phys(phys)
  );

  stk_ctrl #(.OFF_W(OFF_W), .DW(DW), .SEG_SHIFT(SEG_SHIFT)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_data(cmd_data),
    .cmd_seg(cmd_seg), .cmd_ready(cmd_ready),
    .sp(sp), .sp_step(sp_step), .sp_up(sp_up),
    .sel_seg(sel_seg), .sel_off(sel_off), .phys(phys),
    .pop_valid(pop_valid), .pop_data(pop_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/stk_word_checker.sv
module stk_word_checker #(
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BW        = 8,
  localparam int PA_W     = OFF_W + SEG_SHIFT
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_pop,
  input logic [OFF_W-1:0] cmd_seg,
  input logic             cmd_ready,
  input logic [OFF_W-1:0] sp,
  input logic             pop_valid,
  input logic             mem_req,
  input logic             mem_we,
  input logic [PA_W-1:0]  mem_addr,
  input logic [BW-1:0]    mem_wdata,
  input logic             mem_ack
);
  logic [PA_W-1:0]  ck_push_a, ck_pop_a;
  logic [OFF_W-1:0] ck_sp_dn1;

  always_comb begin
    ck_sp_dn1 = sp - OFF_W'(1);
    ck_push_a = (PA_W'(cmd_seg) << SEG_SHIFT) + PA_W'(ck_sp_dn1);
    ck_pop_a  = (PA_W'(cmd_seg) << SEG_SHIFT) + PA_W'(sp);
  end

  p_push_first_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !cmd_pop) |=>
      (mem_req && mem_we && mem_addr == $past(ck_push_a)));

  p_pop_first_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_pop) |=>
      (mem_req && !mem_we && mem_addr == $past(ck_pop_a)));

  p_sp_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mem_ack) |=> $stable(sp));

  p_pop_sp_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we && !cmd_ready) |=>
      (pop_valid || $stable(sp) || sp == $past(sp) + OFF_W'(2)));

  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pop_valid |=> !pop_valid);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_idle_noreq_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_req);
endmodule

bind stack_word_engine stk_word_checker #(
  .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .BW(BW)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
  .cmd_seg(cmd_seg), .cmd_ready(cmd_ready), .sp(sp), .pop_valid(pop_valid),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/stack_word_engine_test.sv
`timescale 1ns/1ps
module stack_word_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_pop = 1'b0;
  logic [15:0] cmd_data = '0, cmd_seg = '0;
  logic        cmd_ready, pop_valid, mem_req, mem_we;
  logic [15:0] sp, pop_data;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int checks = 0, errors = 0;
  int fixed_wait = -1, cnt = -1;
  logic [7:0] ram [logic [19:0]];
  logic [19:0] lg_a [4];
  logic        lg_w [4];
  logic [7:0]  lg_d [4];
  int nlog = 0, npv = 0;
  logic [15:0] pv_data = '0;
  logic [15:0] sp_m = 16'h0000;
  bit watching = 0;
  logic [19:0] w_addr;
  logic w_we;

  always #2.5 clk = ~clk;

  stack_word_engine uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
    .cmd_data(cmd_data), .cmd_seg(cmd_seg), .cmd_ready(cmd_ready), .sp(sp),
    .pop_valid(pop_valid), .pop_data(pop_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({4'h0, s} << 4) + {4'h0, o};
  endfunction

  function automatic logic [7:0] rd(input logic [19:0] a);
    if (ram.exists(a)) return ram[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder with wait states; also logs handshakes and pop strobes
  always @(negedge clk) begin
    if (pop_valid) begin npv++; pv_data = pop_data; end
    if (watching) chk("R9 held request", {11'b0, mem_req, mem_we, mem_addr},
                      {11'b0, 1'b1, w_we, w_addr});
    if (mem_ack) begin mem_ack = 1'b0; cnt = -1; end
    if (mem_req && !mem_ack && !rst) begin
      if (cnt < 0) cnt = (fixed_wait >= 0) ? fixed_wait : int'($urandom % 4);
      if (cnt == 0) begin
        mem_ack = 1'b1;
        if (nlog < 4) begin
          lg_a[nlog] = mem_addr; lg_w[nlog] = mem_we; lg_d[nlog] = mem_wdata;
        end
        nlog++;
        if (mem_we) ram[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
      end else cnt--;
    end
    watching = mem_req && !mem_ack && !rst;
    w_addr = mem_addr; w_we = mem_we;
  end

  task automatic run_cmd(input bit pop, input logic [15:0] seg,
                         input logic [15:0] d, input bit jam);
    logic [15:0] exp_word;
    exp_word = {rd(phys(seg, sp_m + 16'd1)), rd(phys(seg, sp_m))};
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    nlog = 0; npv = 0;
    cmd_valid = 1'b1; cmd_pop = pop; cmd_data = d; cmd_seg = seg;
    @(negedge clk);
    if (jam) begin
      cmd_pop = ~pop; cmd_data = ~d; cmd_seg = ~seg;
      chk("R10 ready low while busy", {31'b0, cmd_ready}, 32'd0);
      @(negedge clk); @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk("R10 two handshakes only", nlog, 2);
    if (!pop) begin
      chk("R2 high byte write", {11'b0, lg_w[0], lg_a[0]}, {11'b0, 1'b1, phys(seg, sp_m - 16'd1)});
      chk("R2 high byte data", {24'b0, lg_d[0]}, {24'b0, d[15:8]});
      chk("R3 low byte write", {11'b0, lg_w[1], lg_a[1]}, {11'b0, 1'b1, phys(seg, sp_m - 16'd2)});
      chk("R3 low byte data", {24'b0, lg_d[1]}, {24'b0, d[7:0]});
      chk("R10 no strobe on push", npv, 0);
      sp_m = sp_m - 16'd2;
      chk("R4 pointer after push", {16'b0, sp}, {16'b0, sp_m});
    end else begin
      chk("R5 low byte read", {11'b0, lg_w[0], lg_a[0]}, {11'b0, 1'b0, phys(seg, sp_m)});
      chk("R5 high byte read", {11'b0, lg_w[1], lg_a[1]}, {11'b0, 1'b0, phys(seg, sp_m + 16'd1)});
      chk("R6 single strobe", npv, 1);
      chk("R6 popped word", {16'b0, pv_data}, {16'b0, exp_word});
      sp_m = sp_m + 16'd2;
      chk("R6 pointer after pop", {16'b0, sp}, {16'b0, sp_m});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BEE5));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pointer", {16'b0, sp}, 32'h0);
    chk("R1 reset flags", {29'b0, cmd_ready, mem_req, pop_valid}, 32'h4);

    // R8: offsets wrap inside 16 bits from pointer zero
    run_cmd(1'b0, 16'h1000, 16'hA1B2, 1'b0);
    chk("R8 wrapped high address", {12'b0, lg_a[0]}, 32'h1FFFF);
    run_cmd(1'b1, 16'h1000, 16'h0000, 1'b0);
    chk("R11 round trip", {16'b0, pv_data}, 32'hA1B2);
    chk("R8 pointer back to zero", {16'b0, sp}, 32'h0);

    // R7: physical address wraps at 20 bits
    run_cmd(1'b0, 16'hFFFF, 16'h3C4D, 1'b0);
    chk("R7 20-bit wrap", {12'b0, lg_a[0]}, 32'h0FFEF);
    run_cmd(1'b1, 16'hFFFF, 16'h0000, 1'b0);
    chk("R11 call/return offset", {16'b0, pv_data}, 32'h3C4D);

    // R10: commands offered while busy are ignored
    fixed_wait = 3;
    run_cmd(1'b0, 16'h0200, 16'h1357, 1'b1);
    run_cmd(1'b1, 16'h0200, 16'h0000, 1'b1);
    chk("R11 after busy jam", {16'b0, pv_data}, 32'h1357);
    fixed_wait = -1;

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] s;
      s = (($urandom % 3) == 0) ? 16'hF000 : {12'h000, 4'($urandom)};
      run_cmd(1'($urandom), s, 16'($urandom), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule